// File: doc/BRIEF.md
# External Bus Wait-State Controller

This controller runs single read and write cycles on an external memory bus. A cycle has three phases: an address phase with the address-latch strobe high, a strobe phase in which the read or write strobe is driven, and a data phase that ends the cycle. A slow device can hold its READY line low to lengthen the strobe phase by whole clocks, called wait states. A 3-bit setting chosen per cycle limits how many wait states READY can add. The limit can be zero to three, or it can be unlimited.

READY comes from outside the clock domain, so it passes through a synchronizer before the controller looks at it. The controller only looks at READY during the strobe phase, because the device decodes READY from an address that is already latched. In unlimited mode, a guard counter ends a cycle whose READY never rises. It then raises a sticky timeout flag, and software clears that flag with a pulse. The requester presents a request with direction, address and write data. It sees a busy flag, a one-clock done pulse, and the captured read data.

Top module: `bus_wait_ctrl`

## Requirements
- R1: With no wait states a cycle takes three clocks after acceptance. The clocks are one with `ale` high, one strobe-phase clock, and one data-phase clock with `done` high. The read or write strobe is high in both the strobe phase and the data phase.
- R2: `wait_cfg` selects the wait-state limit. The encodings are 3'b000, 3'b001, 3'b010 and 3'b011 for limits of 0, 1, 2 and 3. Any value with bit 2 set means unlimited. The value is taken when a request is accepted, and later changes to `wait_cfg` do not affect that cycle.
- R3: If READY stays low for a whole cycle with a limit of 0 to 3, the strobe phase lasts exactly limit + 1 clocks, and then the cycle completes.
- R4: A change on `ready_async` reaches the controller after two clock edges. If READY is seen high before the limit is reached, no further wait states are added. Suppose the request is accepted at edge P0 and READY rises after edge P0+j. The cycle then gets min(j+1, limit) wait states.
- R5: READY is only looked at in the strobe phase. When READY is high for the whole cycle, no wait states are added, whatever the limit.
- R6: `rd_stb` marks read cycles and `wr_stb` marks write cycles. The two strobes are never high together, and neither is high while `ale` is high. `bus_addr` carries the request address through the whole cycle. `bus_wdata` carries the write data during a write.
- R7: `done` is high for exactly one clock, in the data phase. For a read, `rd_data` takes `bus_rdata` at the clock edge that ends the data phase. It keeps that value until the next read completes.
- R8: A request with `req_valid` high is accepted at a clock edge while the controller is idle. `busy` is high from the clock after acceptance through the data phase. `req_valid` has no effect while `busy` is high.
- R9: In unlimited mode, a cycle can be ended by READY or by the guard. If READY is still low when GUARD_LIMIT wait states have been added, the cycle ends and `tmo_flag` is set by the data phase.
- R10: `tmo_flag` stays set until a `tmo_clear` pulse clears it. If a new timeout and a clear happen in the same clock, the timeout wins.
- R11: After reset the controller is idle. `ale`, both strobes, `busy`, `done`, `tmo_flag` and `rd_data` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | AW | Address of the requested cycle |
| req_wdata | input | DW | Write data of the requested cycle |
| wait_cfg | input | 3 | Wait-state limit selection |
| ready_async | input | 1 | Device ready, low inserts wait states, asynchronous |
| bus_rdata | input | DW | Data returned by the device |
| tmo_clear | input | 1 | Clears the timeout flag |
| ale | output | 1 | Address-latch strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-clock end-of-cycle pulse |
| rd_data | output | DW | Data captured at the end of the last read |
| tmo_flag | output | 1 | Sticky guard-timeout flag |

## Verification
The hardest conditions to reach are an early READY release at an exact wait count and the guard expiring in unlimited mode. The synchronizer delays READY by two edges, so the release has to be timed relative to the acceptance edge. The bench counts edges from acceptance, raises READY after a chosen number of them, and predicts min(j+1, limit) wait states from that count. For the guard case, the bench builds the controller with a short guard limit and holds READY low until the cycle finishes. This shows the forced end, the sticky flag, and the clear that follows.

// File: rtl/bw_pkg.sv
package bw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2,
        PH_DATA = 2'd3
    } bw_phase_e;

    typedef struct packed {
        logic       unlimited;
        logic [1:0] count;
    } bw_cap_t;

    function automatic bw_cap_t bw_decode_cap(input logic [2:0] cfg);
        bw_cap_t c;
        c.unlimited = cfg[2];
        c.count     = cfg[2] ? 2'd0 : cfg[1:0];
        return c;
    endfunction

endpackage

// File: rtl/bw_ready_sync.sv
module bw_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (STAGES < 2) begin : g_single
            logic sync_d, sync_q;
            always_comb sync_d = din;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= 1'b1;
                else        sync_q <= sync_d;
            end
            assign dout = sync_q;
        end else begin : g_chain
            logic [STAGES-1:0] chain_d, chain_q;
            always_comb chain_d = {chain_q[STAGES-2:0], din};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= chain_d;
            end
            assign dout = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/bw_wait_tracker.sv
module bw_wait_tracker
    import bw_pkg::*;
#(
    parameter int GUARD_LIMIT = 255
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    in_strobe,
    input  logic    ready_s,
    input  bw_cap_t cap,
    input  logic    tmo_clear,
    output logic    stretch,
    output logic    tmo_flag
);
    localparam int CW = $clog2(GUARD_LIMIT + 1) < 2 ? 2 : $clog2(GUARD_LIMIT + 1);
    localparam logic [CW-1:0] GUARD_C = CW'(GUARD_LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tmo;
    } trk_t;

    trk_t q, d;
    logic [CW-1:0] cap_ext;
    logic          below_cap;
    logic          guard_hit;

    always_comb begin
        cap_ext   = CW'(cap.count);
        below_cap = cap.unlimited ? (q.cnt < GUARD_C) : (q.cnt < cap_ext);
        stretch   = in_strobe && !ready_s && below_cap;
        guard_hit = in_strobe && !ready_s && cap.unlimited && !below_cap;

        d = q;
        if (start)        d.cnt = '0;
        else if (stretch) d.cnt = q.cnt + 1'b1;

        if (guard_hit)      d.tmo = 1'b1;
        else if (tmo_clear) d.tmo = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tmo_flag = q.tmo;

    AST_GUARD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= GUARD_C); // R9
    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && !cap.unlimited) |-> (q.cnt <= cap_ext)); // R3
    AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_flag && !tmo_clear) |=> tmo_flag); // R10
    AST_TMO_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_strobe && !ready_s && cap.unlimited && q.cnt == GUARD_C) |=> tmo_flag); // R10
endmodule

// File: rtl/bus_wait_ctrl.sv
module bus_wait_ctrl
    import bw_pkg::*;
#(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int GUARD_LIMIT = 255,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [2:0]    wait_cfg,
    input  logic          ready_async,
    input  logic [DW-1:0] bus_rdata,
    input  logic          tmo_clear,
    output logic          ale,
    output logic          rd_stb,
    output logic          wr_stb,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          tmo_flag
);
    typedef struct packed {
        bw_phase_e     phase;
        logic          write;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        bw_cap_t       cap;
        logic [DW-1:0] rdata;
    } ctl_t;

    ctl_t q, d;
    logic ready_s;
    logic stretch;

    bw_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ready_async),
        .dout (ready_s)
    );

    bw_wait_tracker #(.GUARD_LIMIT(GUARD_LIMIT)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (q.phase == PH_ADDR),
        .in_strobe(q.phase == PH_STRB),
        .ready_s  (ready_s),
        .cap      (q.cap),
        .tmo_clear(tmo_clear),
        .stretch  (stretch),
        .tmo_flag (tmo_flag)
    );

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    d.phase = PH_ADDR;
                    d.write = req_write;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.cap   = bw_decode_cap(wait_cfg);
                end
            end
            PH_ADDR: d.phase = PH_STRB;
            PH_STRB: begin
                if (!stretch) d.phase = PH_DATA;
            end
            PH_DATA: begin
                d.phase = PH_IDLE;
                if (!q.write) d.rdata = bus_rdata;
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ale       = (q.phase == PH_ADDR);
        rd_stb    = !q.write && ((q.phase == PH_STRB) || (q.phase == PH_DATA));
        wr_stb    =  q.write && ((q.phase == PH_STRB) || (q.phase == PH_DATA));
        busy      = (q.phase != PH_IDLE);
        done      = (q.phase == PH_DATA);
        bus_addr  = q.addr;
        bus_wdata = q.wdata;
        rd_data   = q.rdata;
    end

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> (!ale && (rd_stb || wr_stb))); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb && wr_stb) && !(ale && (rd_stb || wr_stb))); // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R7
    AST_READY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_STRB && ready_s) |=> done); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(bus_addr)); // R8
endmodule

// File: tb/bus_wait_ctrl_tb.sv
module bus_wait_ctrl_tb;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int GL = 20;
    localparam int NEVER = 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [2:0] wait_cfg = 3'b000;
    logic ready_async = 1'b1;
    logic [DW-1:0] bus_rdata = '0;
    logic tmo_clear = 1'b0;
    logic ale, rd_stb, wr_stb, busy, done, tmo_flag;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, rd_data;

    int checks = 0, errors = 0, ale_seen = 0, cycles_run = 0;
    bit finished = 0;

    typedef struct {
        bit            wr;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        int            waits;
        bit            tmo;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    bus_wait_ctrl #(.AW(AW), .DW(DW), .GUARD_LIMIT(GL), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .wait_cfg(wait_cfg),
        .ready_async(ready_async), .bus_rdata(bus_rdata), .tmo_clear(tmo_clear),
        .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .busy(busy), .done(done), .rd_data(rd_data),
        .tmo_flag(tmo_flag)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // rel < 0: READY high throughout; else READY rises after rel edges past acceptance
    task automatic run_cycle(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input logic [DW-1:0] rd, input logic [2:0] cfg, input int rel,
                             input bit poke_busy);
        exp_t e;
        int cap;
        cap = cfg[2] ? GL : int'(cfg[1:0]);
        e.wr = wr; e.addr = a; e.wdata = wd; e.rdata = rd;
        if (rel < 0) begin
            e.waits = 0; e.tmo = 0;
        end else begin
            e.waits = (rel + 1 < cap) ? rel + 1 : cap;
            e.tmo   = cfg[2] && (rel + 1 > GL);
        end
        sb.push_back(e);
        @(negedge clk);
        ready_async = (rel < 0);
        bus_rdata = rd;
        repeat (3) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; wait_cfg = cfg;
        @(negedge clk);
        req_valid = 1'b0;
        wait_cfg = 3'b000;
        cycles_run++;
        check(busy && ale, "R8 busy and ale after accept", {busy, ale}, 2'b11);
        if (poke_busy) begin
            req_valid = 1'b1; req_addr = ~a; req_write = ~wr;
            @(negedge clk);
            req_valid = 1'b0;
        end
        if (rel >= 0 && rel < NEVER) begin
            repeat (rel - (poke_busy ? 1 : 0)) @(negedge clk);
            ready_async = 1'b1;
        end
        while (busy) @(negedge clk);
        ready_async = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // monitor / scoreboard
    initial begin
        int stb_cnt = 0;
        bit prev_done = 0, rd_pending = 0;
        exp_t cur;
        wait (rst_n);
        forever begin
            @(negedge clk);
            if (rd_pending) begin
                check(rd_data == cur.rdata, "R7 read data capture", rd_data, cur.rdata);
                rd_pending = 0;
            end
            if (ale) begin
                ale_seen++;
                stb_cnt = 0;
            end
            if ((rd_stb || wr_stb) && !done) stb_cnt++;
            if (done) begin
                check(!prev_done, "R7 done one clock", prev_done, 0);
                if (sb.size() == 0) begin
                    check(0, "R8 unexpected cycle", 1, 0);
                end else begin
                    cur = sb.pop_front();
                    check(stb_cnt - 1 == cur.waits, "R3 R4 R5 wait states", stb_cnt - 1, cur.waits);
                    check(wr_stb == cur.wr && rd_stb == !cur.wr, "R6 strobe direction",
                          {rd_stb, wr_stb}, {!cur.wr, cur.wr});
                    check(bus_addr == cur.addr, "R6 bus address", bus_addr, cur.addr);
                    if (cur.wr) check(bus_wdata == cur.wdata, "R6 write data", bus_wdata, cur.wdata);
                    else        rd_pending = 1;
                    check(tmo_flag == cur.tmo, "R9 timeout flag", tmo_flag, cur.tmo);
                end
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({ale, rd_stb, wr_stb, busy, done, tmo_flag} == 6'b0, "R11 reset outputs",
              {ale, rd_stb, wr_stb, busy, done, tmo_flag}, 0);
        check(rd_data == '0, "R11 reset rd_data", rd_data, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 zero-wait write and read
        run_cycle(1, 16'h1234, 16'hA5A5, 16'h0000, 3'b000, -1, 0);
        run_cycle(0, 16'h2000, 16'h0000, 16'hBEEF, 3'b000, -1, 0);
        // R5 READY high with every limit
        run_cycle(0, 16'h2002, 16'h0000, 16'h1111, 3'b011, -1, 0);
        run_cycle(1, 16'h2004, 16'h5555, 16'h0000, 3'b100, -1, 0);
        // R3 READY low: exact cap, R2 encodings
        run_cycle(0, 16'h3000, 16'h0000, 16'h0A0A, 3'b000, NEVER, 0);
        run_cycle(1, 16'h3001, 16'h7E7E, 16'h0000, 3'b001, NEVER, 0);
        run_cycle(0, 16'h3002, 16'h0000, 16'hC0DE, 3'b010, NEVER, 0);
        run_cycle(1, 16'h3003, 16'h1357, 16'h0000, 3'b011, NEVER, 1); // R8 poke while busy
        // R4 early release
        run_cycle(0, 16'h4000, 16'h0000, 16'h4444, 3'b011, 0, 0);
        run_cycle(0, 16'h4001, 16'h0000, 16'h4545, 3'b011, 1, 0);
        run_cycle(1, 16'h4002, 16'h9999, 16'h0000, 3'b111, 9, 0);
        check(tmo_flag == 0, "R9 no timeout when READY ends", tmo_flag, 0);
        // R9 guard expiry
        run_cycle(0, 16'h5000, 16'h0000, 16'hDEAD, 3'b101, NEVER, 0);
        repeat (5) @(negedge clk);
        check(tmo_flag == 1, "R10 flag sticky", tmo_flag, 1);
        tmo_clear = 1'b1;
        @(negedge clk);
        tmo_clear = 1'b0;
        check(tmo_flag == 0, "R10 flag cleared", tmo_flag, 0);
        check(rd_data == 16'hDEAD, "R7 rd_data held", rd_data, 16'hDEAD);
        repeat (5) @(negedge clk);
        check(ale_seen == cycles_run, "R8 busy requests ignored", ale_seen, cycles_run);
        check(sb.size() == 0, "R8 all cycles completed", sb.size(), 0);
        finish_run();
    end
endmodule